// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller

This block sits on an 8-bit register bus and runs a 32-input analog multiplexer together with an external 16-bit converter. Software sets a first and a last channel, a range and settling code, and a queue control that picks either a single conversion or a scan mode. Any write to the trigger address then starts one conversion sequence. The controller presents each channel to the converter in turn and pushes each 16-bit two's-complement result into a 16-word result queue. Software reads each result back as a low byte and then a high byte.

Two busy indications are kept apart. Conversion busy covers the whole sequence. Settling busy is a timer that runs after any change to the channel or setup registers, and a trigger that arrives while it runs is held until it expires. An end-of-sequence interrupt can be enabled, read back, acknowledged and disabled. A command write resets every register. Known readback values after reset let software detect that the block is present.

The sequencer is a four-state machine. SQ_IDLE waits for a latched trigger. It moves to SQ_HOLD when settling is busy and to SQ_LAUNCH otherwise. SQ_HOLD waits until settling ends and then moves to SQ_LAUNCH. SQ_LAUNCH pulses `conv_start` for the current channel and moves to SQ_CONV, but it returns to SQ_HOLD if settling has restarted. SQ_CONV waits for `conv_done` and stores the result. It then either steps to the next channel (back to SQ_LAUNCH) or finishes the sequence (back to SQ_IDLE).

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, reads return 0x00 at addresses 2, 3, 9 and 11, 0x80 at address 7 and 0x60 at address 8. After writing 0x80 to address 2, 0xFF to address 3 and 0x0C to address 11, and once settling has ended, the reads return 0x00, 0x1F, 0x80, 0x60, 0x00 and 0x0C.
- R2: The first-channel register (address 2) and the last-channel register (address 3) keep only data bits 4:0 and read back with bits 7:5 zero.
- R3: With scan mode off, a trigger (any write to address 0) converts only the first channel, once. Reading address 0 returns bits 7:0 of the oldest stored result without removing it. Reading address 1 returns bits 15:8 and removes that result. Every 16-bit pattern, including 0x8000 and 0x7FFF, is returned unchanged.
- R4: With scan mode on, a trigger converts every channel from the first channel up to the last channel in ascending order, wrapping from 31 to 0 when the last channel is below the first. Each channel is launched exactly once.
- R5: Status address 8 reads {busy, 1, 1, channel[4:0]}. Busy is bit 7 and is set from the cycle after an accepted trigger until the last result of the sequence is stored. Bits 4:0 give the channel most recently selected. A trigger written while busy is ignored.
- R6: A write to address 2, 3 or 11 makes settling busy (address 11, bit 7) for SETTLE_UNIT×(4−code) cycles. The code is data bits 5:4 of the write to address 11, or the stored code for a write to address 2 or 3. So code 00 gives the longest delay and code 11 the shortest.
- R7: A trigger accepted while settling is busy launches no conversion until settling busy has cleared.
- R8: The result queue holds FIFO_DEPTH words. Address 7 reads bit 7 = empty, bit 6 = full and the other bits zero. A result that arrives while the queue is full is dropped. Reading the queue while it is empty returns 0x00 and removes nothing.
- R9: A write to address 7 with bit 1 set empties the queue. The same write stores bit 2 as the scan-mode enable.
- R10: Address 9 stores bit 7 as the interrupt enable and bits 1:0 as a clock select. It reads {pending, 00000, select}. When a sequence ends with the enable set, pending goes high, and the `irq` pin follows pending.
- R11: A write to address 8 with bit 3 set clears pending. A write to address 9 with bit 7 clear also clears pending and disables further interrupts.
- R12: A write to address 8 with bit 5 set returns every register, the queue and the sequencer to their reset state. This takes priority over the other bits of the same write.
- R13: Address 11 reads {settling busy, 0, setup[5:0]}. Setup bits 3:0 hold the range code (0x0C, 0x0D, 0x08 or 0x00) and bits 5:4 hold the settling code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (causes a queue pop at address 1) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | End-of-sequence interrupt |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 5 | Multiplexer channel for the conversion |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 16 | Converter result, two's complement |

## Verification
The bench builds the block with SETTLE_UNIT set to 3 and keeps the 16-word queue. With these values every settling window lasts 3 to 12 cycles, so the bench can count each window one cycle at a time, and a trigger written straight after a setup write always lands inside a window. A full 0 to 31 scan produces twice as many results as the queue holds, which brings the full flag and the dropping of results within reach. A converter model with a five-cycle delay returns 0x8000 on channel 0, 0x7FFF on channel 1 and a channel-tagged pattern elsewhere, so both extreme values and the channel order can be seen in what is read back.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    // Register addresses on the 8-bit bus
    localparam logic [3:0] A_RES_LO   = 4'd0;
    localparam logic [3:0] A_RES_HI   = 4'd1;
    localparam logic [3:0] A_CH_FIRST = 4'd2;
    localparam logic [3:0] A_CH_LAST  = 4'd3;
    localparam logic [3:0] A_QUEUE    = 4'd7;
    localparam logic [3:0] A_CMD      = 4'd8;
    localparam logic [3:0] A_INTR     = 4'd9;
    localparam logic [3:0] A_SETUP    = 4'd11;

    // Bit positions inside written bytes
    localparam int B_Q_FLUSH   = 1;
    localparam int B_Q_SCAN    = 2;
    localparam int B_CMD_ACK   = 3;
    localparam int B_CMD_RESET = 5;
    localparam int B_INT_EN    = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_LAUNCH,
        SQ_CONV
    } sq_state_t;

    // Settling code 00 is the slowest (4 units), 11 the fastest (1 unit)
    function automatic logic [2:0] settle_steps(input logic [1:0] code);
        return 3'd4 - {1'b0, code};
    endfunction

endpackage

// File: rtl/ascan_regs.sv
module ascan_regs
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W      = 5,
    parameter int SETTLE_UNIT = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              seq_done,
    output logic              soft_clr,
    output logic              trig_wr,
    output logic              flush,
    output logic [CHAN_W-1:0] lo_ch,
    output logic [CHAN_W-1:0] hi_ch,
    output logic              scan_en,
    output logic [5:0]        setup,
    output logic              int_en,
    output logic [1:0]        clk_sel,
    output logic              int_pend,
    output logic              settle_busy
);

    localparam int SETTLE_MAX = SETTLE_UNIT * 4;
    localparam int SW         = $clog2(SETTLE_MAX + 1);

    logic [SW-1:0] settle_cnt;
    logic          ack;
    logic          settle_load;
    logic [1:0]    load_code;

    always_comb begin
        soft_clr    = wr_en && (addr == A_CMD) && wdata[B_CMD_RESET];
        ack         = wr_en && (addr == A_CMD) && wdata[B_CMD_ACK];
        trig_wr     = wr_en && (addr == A_RES_LO);
        flush       = wr_en && (addr == A_QUEUE) && wdata[B_Q_FLUSH];
        settle_load = wr_en && ((addr == A_CH_FIRST) || (addr == A_CH_LAST) ||
                                (addr == A_SETUP));
        load_code   = (addr == A_SETUP) ? wdata[5:4] : setup[5:4];
        settle_busy = (settle_cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_ch      <= '0;
            hi_ch      <= '0;
            scan_en    <= 1'b0;
            setup      <= '0;
            int_en     <= 1'b0;
            clk_sel    <= '0;
            int_pend   <= 1'b0;
            settle_cnt <= '0;
        end else if (soft_clr) begin
            lo_ch      <= '0;
            hi_ch      <= '0;
            scan_en    <= 1'b0;
            setup      <= '0;
            int_en     <= 1'b0;
            clk_sel    <= '0;
            int_pend   <= 1'b0;
            settle_cnt <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    A_CH_FIRST: lo_ch   <= wdata[CHAN_W-1:0];
                    A_CH_LAST:  hi_ch   <= wdata[CHAN_W-1:0];
                    A_QUEUE:    scan_en <= wdata[B_Q_SCAN];
                    A_SETUP:    setup   <= wdata[5:0];
                    A_INTR: begin
                        int_en  <= wdata[B_INT_EN];
                        clk_sel <= wdata[1:0];
                    end
                    default: ;
                endcase
            end

            if (seq_done && int_en)
                int_pend <= 1'b1;
            else if (ack || (wr_en && (addr == A_INTR) && !wdata[B_INT_EN]))
                int_pend <= 1'b0;

            if (settle_load)
                settle_cnt <= SW'(SETTLE_UNIT * int'(settle_steps(load_code)));
            else if (settle_cnt != '0)
                settle_cnt <= settle_cnt - 1'b1;
        end
    end

    AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_load && !soft_clr) |=> settle_busy); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !seq_done && !soft_clr) |=> !int_pend); // R11

endmodule

// File: rtl/ascan_fifo.sv
module ascan_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> $stable(count)); // R8

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty); // R8

endmodule

// File: rtl/ascan_seq.sv
module ascan_seq
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              trig_wr,
    input  logic              scan_en,
    input  logic [CHAN_W-1:0] lo_ch,
    input  logic [CHAN_W-1:0] hi_ch,
    input  logic              settle_busy,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              seq_done,
    output logic              busy
);

    sq_state_t         state, nxt_state;
    logic              trig_pend, nxt_pend;
    logic [CHAN_W-1:0] ptr, nxt_ptr;
    logic [CHAN_W-1:0] stop_ch, nxt_stop;
    logic              scan_q, nxt_scan;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            trig_pend <= 1'b0;
            ptr       <= '0;
            stop_ch   <= '0;
            scan_q    <= 1'b0;
        end else if (clr) begin
            state     <= SQ_IDLE;
            trig_pend <= 1'b0;
            ptr       <= '0;
            stop_ch   <= '0;
            scan_q    <= 1'b0;
        end else begin
            state     <= nxt_state;
            trig_pend <= nxt_pend;
            ptr       <= nxt_ptr;
            stop_ch   <= nxt_stop;
            scan_q    <= nxt_scan;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt_state  = state;
        nxt_pend   = trig_pend;
        nxt_ptr    = ptr;
        nxt_stop   = stop_ch;
        nxt_scan   = scan_q;
        conv_start = 1'b0;
        push       = 1'b0;
        seq_done   = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (trig_pend) begin
                    nxt_pend  = 1'b0;
                    nxt_ptr   = lo_ch;
                    nxt_stop  = hi_ch;
                    nxt_scan  = scan_en;
                    nxt_state = settle_busy ? SQ_HOLD : SQ_LAUNCH;
                end else if (trig_wr) begin
                    nxt_pend = 1'b1;
                end
            end
            SQ_HOLD: begin
                if (!settle_busy)
                    nxt_state = SQ_LAUNCH;
            end
            SQ_LAUNCH: begin
                if (settle_busy) begin
                    nxt_state = SQ_HOLD;
                end else begin
                    conv_start = 1'b1;
                    nxt_state  = SQ_CONV;
                end
            end
            SQ_CONV: begin
                if (conv_done) begin
                    push = 1'b1;
                    if (scan_q && (ptr != stop_ch)) begin
                        nxt_ptr   = ptr + 1'b1;
                        nxt_state = SQ_LAUNCH;
                    end else begin
                        seq_done  = 1'b1;
                        nxt_state = SQ_IDLE;
                    end
                end
            end
            default: nxt_state = SQ_IDLE;
        endcase
    end

    always_comb begin
        conv_chan = ptr;
        push_data = conv_data;
        busy      = trig_pend || (state != SQ_IDLE);
    end

    AST_HOLD_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD && settle_busy && !clr) |=> !conv_start); // R7

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W      = 5,
    parameter int FIFO_DEPTH  = 16,
    parameter int SETTLE_UNIT = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [15:0]       conv_data
);

    localparam int DATA_W = 16;

    logic              soft_clr, trig_wr, flush;
    logic [CHAN_W-1:0] lo_ch, hi_ch;
    logic              scan_en, int_en, int_pend, settle_busy;
    logic [5:0]        setup;
    logic [1:0]        clk_sel;
    logic              seq_done, busy, push, pop;
    logic [DATA_W-1:0] push_data, q_head;
    logic              q_empty, q_full;

    ascan_regs #(
        .CHAN_W      (CHAN_W),
        .SETTLE_UNIT (SETTLE_UNIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .seq_done    (seq_done),
        .soft_clr    (soft_clr),
        .trig_wr     (trig_wr),
        .flush       (flush),
        .lo_ch       (lo_ch),
        .hi_ch       (hi_ch),
        .scan_en     (scan_en),
        .setup       (setup),
        .int_en      (int_en),
        .clk_sel     (clk_sel),
        .int_pend    (int_pend),
        .settle_busy (settle_busy)
    );

    ascan_seq #(
        .CHAN_W (CHAN_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (soft_clr),
        .trig_wr     (trig_wr),
        .scan_en     (scan_en),
        .lo_ch       (lo_ch),
        .hi_ch       (hi_ch),
        .settle_busy (settle_busy),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .push        (push),
        .push_data   (push_data),
        .seq_done    (seq_done),
        .busy        (busy)
    );

    ascan_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush || soft_clr),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    always_comb begin
        pop = bus_rd && (bus_addr == A_RES_HI);
        irq = int_pend;
        case (bus_addr)
            A_RES_LO:   bus_rdata = q_empty ? 8'h00 : q_head[7:0];
            A_RES_HI:   bus_rdata = q_empty ? 8'h00 : q_head[15:8];
            A_CH_FIRST: bus_rdata = 8'(lo_ch);
            A_CH_LAST:  bus_rdata = 8'(hi_ch);
            A_QUEUE:    bus_rdata = {q_empty, q_full, 6'b0};
            A_CMD:      bus_rdata = {busy, 2'b11, 5'(conv_chan)};
            A_INTR:     bus_rdata = {int_pend, 5'b0, clk_sel};
            A_SETUP:    bus_rdata = {settle_busy, 1'b0, setup};
            default:    bus_rdata = 8'h00;
        endcase
    end

    AST_TRIG_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && !busy && !soft_clr) |=> busy); // R5

    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !conv_start); // R5

endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
    import adc_scan_pkg::*;

    localparam int UNIT  = 3;
    localparam int LAT   = 5;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, conv_start;
    logic [4:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [15:0] conv_data = '0;

    int vecs = 0;
    int errs = 0;
    logic [7:0] salt = 8'h00;
    logic [4:0] st_ch = '0;
    int st_cnt = 0;
    int starts = 0;

    always #5 clk = ~clk;

    adc_scan_ctrl #(.CHAN_W(5), .FIFO_DEPTH(DEPTH), .SETTLE_UNIT(UNIT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data)
    );

    function automatic logic [15:0] exp_word(input logic [4:0] ch, input logic [7:0] s);
        if (ch == 5'd0) return 16'h8000;
        if (ch == 5'd1) return 16'h7FFF;
        return {3'b101, ch, s};
    endfunction

    function automatic int seq_len(input logic [4:0] lo, input logic [4:0] hi, input bit scan);
        return scan ? int'(5'(hi - lo)) + 1 : 1;
    endfunction

    // Converter model: fixed latency, result depends on channel and salt
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            st_ch  <= conv_chan;
            st_cnt <= LAT;
            starts <= starts + 1;
        end else if (st_cnt > 0) begin
            st_cnt <= st_cnt - 1;
            if (st_cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= exp_word(st_ch, salt);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(A_CMD, s);
            if (!s[7]) return;
        end
        chk("R5 busy never cleared", 1, 0);
    endtask

    task automatic wait_settled();
        logic [7:0] s;
        for (int i = 0; i < 100; i++) begin
            rd(A_SETUP, s);
            if (!s[7]) return;
        end
        chk("R6 settling never ended", 1, 0);
    endtask

    task automatic drain(input logic [4:0] lo, input int n, input string tag);
        logic [7:0] l, h;
        for (int k = 0; k < n; k++) begin
            rd(A_RES_LO, l);
            rd(A_RES_HI, h);
            chk(tag, {h, l}, exp_word(5'(int'(lo) + k), salt));
        end
    endtask

    task automatic run_scan(input logic [4:0] lo, input logic [4:0] hi, input bit scan,
                            input logic [7:0] s);
        salt = s;
        wr(A_QUEUE, {5'b0, scan, 2'b10});
        wr(A_CH_FIRST, 8'(lo));
        wr(A_CH_LAST, 8'(hi));
        wr(A_RES_LO, 8'hFF);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n, cnt, s0;
        bit moved;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset readback
        rd(A_CH_FIRST, v); chk("R1 first after reset", v, 8'h00);
        rd(A_CH_LAST, v);  chk("R1 last after reset", v, 8'h00);
        rd(A_QUEUE, v);    chk("R1 queue after reset", v, 8'h80);
        rd(A_CMD, v);      chk("R1 status after reset", v, 8'h60);
        rd(A_INTR, v);     chk("R1 intr after reset", v, 8'h00);
        rd(A_SETUP, v);    chk("R1 setup after reset", v, 8'h00);
        chk("R1 irq after reset", irq, 1'b0);

        // R1 / R2 / R13 detection sequence
        wr(A_CH_FIRST, 8'h80);
        wr(A_CH_LAST, 8'hFF);
        wr(A_SETUP, 8'h0C);
        wait_settled();
        rd(A_CH_FIRST, v); chk("R2 first keeps 5 bits", v, 8'h00);
        rd(A_CH_LAST, v);  chk("R2 last keeps 5 bits", v, 8'h1F);
        rd(A_QUEUE, v);    chk("R1 queue detect", v, 8'h80);
        rd(A_CMD, v);      chk("R1 status detect", v, 8'h60);
        rd(A_INTR, v);     chk("R1 intr detect", v, 8'h00);
        rd(A_SETUP, v);    chk("R13 setup detect", v, 8'h0C);

        // R6 settling window lengths
        wr(A_SETUP, 8'h0C); cnt = 0;
        do begin rd(A_SETUP, v); if (v[7]) cnt++; end while (v[7] && cnt < 100);
        chk("R6 window code 00", cnt, 4 * UNIT);
        wr(A_SETUP, 8'h3D); cnt = 0;
        do begin rd(A_SETUP, v); if (v[7]) cnt++; end while (v[7] && cnt < 100);
        chk("R6 window code 11", cnt, UNIT);
        chk("R13 setup readback", v, 8'h3D);
        wr(A_SETUP, 8'h28); wait_settled();
        wr(A_CH_FIRST, 8'h04); cnt = 0;
        do begin rd(A_SETUP, v); if (v[7]) cnt++; end while (v[7] && cnt < 100);
        chk("R6 channel write uses stored code 10", cnt, 2 * UNIT);

        // R3 single conversions at the extremes, peek without pop
        run_scan(5'd0, 5'd9, 1'b0, 8'h11);
        rd(A_QUEUE, v); chk("R8 one result not empty", v, 8'h00);
        rd(A_RES_LO, v); rd(A_RES_LO, v2);
        chk("R3 low byte read does not pop", v2, v);
        drain(5'd0, 1, "R3 single ch0 word");
        run_scan(5'd1, 5'd1, 1'b0, 8'h22);
        drain(5'd1, 1, "R3 single ch1 word");
        rd(A_QUEUE, v);  chk("R8 empty after drain", v, 8'h80);
        rd(A_RES_HI, v); chk("R8 empty high read", v, 8'h00);
        rd(A_RES_LO, v); chk("R8 empty low read", v, 8'h00);

        // R7 trigger during settling is held
        wr(A_QUEUE, 8'h02);
        wr(A_CH_FIRST, 8'd6);
        wr(A_SETUP, 8'h0C);
        s0 = starts;
        wr(A_RES_LO, 8'h00);
        moved = 1'b0;
        do begin rd(A_SETUP, v); if (v[7] && starts != s0) moved = 1'b1; end while (v[7]);
        chk("R7 no launch while settling", moved, 1'b0);
        wait_idle();
        chk("R7 launched after settling", starts - s0, 1);
        drain(5'd6, 1, "R7 held conversion result");

        // R5 busy, ignored retrigger, channel field
        salt = 8'h5A;
        wr(A_QUEUE, 8'h06);
        wr(A_CH_FIRST, 8'd4);
        wr(A_CH_LAST, 8'd7);
        s0 = starts;
        wr(A_RES_LO, 8'h01);
        rd(A_CMD, v); chk("R5 busy after trigger", v[7], 1'b1);
        wr(A_RES_LO, 8'h01);
        wait_idle();
        chk("R5 retrigger ignored", starts - s0, 4);
        rd(A_CMD, v); chk("R5 status channel field", v, 8'h67);
        drain(5'd4, 4, "R4 ascending scan 4..7");
        rd(A_QUEUE, v); chk("R5 no extra results", v, 8'h80);

        // R4 wrap-around scan
        run_scan(5'd30, 5'd1, 1'b1, 8'hC3);
        drain(5'd30, 4, "R4 wrapping scan 30..1");

        // R8 overflow and R9 flush
        run_scan(5'd0, 5'd31, 1'b1, 8'h77);
        rd(A_QUEUE, v); chk("R8 full flag", v, 8'h40);
        drain(5'd0, DEPTH, "R8 kept oldest results");
        rd(A_QUEUE, v); chk("R8 extra results dropped", v, 8'h80);
        run_scan(5'd2, 5'd5, 1'b1, 8'h19);
        wr(A_QUEUE, 8'h02);
        rd(A_QUEUE, v); chk("R9 flush empties", v, 8'h80);

        // R10 / R11 interrupt
        wr(A_INTR, 8'h83);
        run_scan(5'd8, 5'd9, 1'b1, 8'h01);
        rd(A_INTR, v); chk("R10 pending after sequence", v, 8'h83);
        chk("R10 irq pin high", irq, 1'b1);
        wr(A_CMD, 8'h08);
        rd(A_INTR, v); chk("R11 ack clears pending", v, 8'h03);
        chk("R11 irq pin low after ack", irq, 1'b0);
        run_scan(5'd8, 5'd8, 1'b0, 8'h02);
        chk("R10 irq again", irq, 1'b1);
        wr(A_INTR, 8'h00);
        rd(A_INTR, v); chk("R11 disable clears", v, 8'h00);
        chk("R11 irq low after disable", irq, 1'b0);
        run_scan(5'd8, 5'd8, 1'b0, 8'h03);
        rd(A_INTR, v); chk("R10 no pending when disabled", v, 8'h00);

        // R12 soft reset
        wr(A_INTR, 8'h81);
        wr(A_SETUP, 8'h2D);
        run_scan(5'd5, 5'd9, 1'b1, 8'h44);
        wr(A_CMD, 8'h28);
        rd(A_CH_FIRST, v); chk("R12 first cleared", v, 8'h00);
        rd(A_CH_LAST, v);  chk("R12 last cleared", v, 8'h00);
        rd(A_QUEUE, v);    chk("R12 queue cleared", v, 8'h80);
        rd(A_CMD, v);      chk("R12 status cleared", v, 8'h60);
        rd(A_INTR, v);     chk("R12 intr cleared", v, 8'h00);
        rd(A_SETUP, v);    chk("R12 setup cleared", v, 8'h00);
        chk("R12 irq low", irq, 1'b0);

        // Random sequences (R3, R4, R8)
        for (int it = 0; it < 25; it++) begin
            logic [4:0] lo, hi;
            bit sc;
            logic [1:0] code;
            lo   = 5'($urandom % 32);
            hi   = 5'($urandom % 32);
            sc   = 1'($urandom % 2);
            code = 2'($urandom % 4);
            wr(A_SETUP, {2'b00, code, 4'h8});
            run_scan(lo, hi, sc, 8'($urandom));
            n = seq_len(lo, hi, sc);
            rd(A_CMD, v);
            chk(sc ? "R4 random last channel" : "R3 random channel", v, {3'b011, sc ? hi : lo});
            rd(A_QUEUE, v);
            chk("R8 random queue flags", v, (n >= DEPTH) ? 8'h40 : 8'h00);
            drain(lo, (n > DEPTH) ? DEPTH : n, sc ? "R4 random scan word" : "R3 random word");
            rd(A_QUEUE, v);
            chk("R8 random drained", v, 8'h80);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule